// File: doc/BRIEF.md
# Paged memory-reference execution sequencer

This block is the control core of a 12-bit accumulator machine. It steps through instruction fetch, an optional pointer-follow step and operand execution for the six memory-reference operations. It keeps a 12-bit accumulator, a 1-bit link and a 12-bit program counter. It talks to one synchronous single-port memory of 4096 words. A read strobe in one cycle returns data in the next cycle. A write strobe commits at the end of its cycle.

The operand address is built from a 7-bit offset taken from the instruction. The offset sits either in page zero or in the page of the instruction word itself, and one level of pointer indirection may follow.

Words with opcode 6 or 7 are not executed here. They are handed to a neighbouring unit through a one-cycle valid pulse that carries the word. The sequencer then stalls until that unit raises its done input. This done input is the only back-pressure the block sees. The memory side has fixed timing and never stalls.

Top module: `pgref_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the program counter equals the RESET_PC parameter, the accumulator and link are 0, and the block drives a read strobe at address RESET_PC.
- R2: Instruction word layout, with bit 11 the most significant: bits 11..9 are the opcode, bit 8 is the indirect flag, bit 7 is the page flag and bits 6..0 are the offset. With the page flag at 0, the address formed is the offset zero-extended (locations 0000..0177 octal).
- R3: With the page flag at 1, the formed address is the upper five bits of the instruction's own address joined to the offset. This holds even when the instruction is the last word of its page.
- R4: With the indirect flag at 1, the word read at the formed address becomes the full 12-bit effective address. This adds exactly two cycles.
- R5: Opcode 0 replaces the accumulator with the bitwise AND of the accumulator and the operand. The link is unchanged.
- R6: Opcode 1 adds the operand to the accumulator modulo 4096. A carry out of the top bit inverts the link. The link does not feed the sum.
- R7: Opcode 2 reads the word at the effective address and writes it back plus 1 in the next cycle to the same address. When the written value is 0, the next instruction is skipped. The accumulator and link are unchanged.
- R8: Opcode 3 writes the accumulator to the effective address, then clears the accumulator.
- R9: Opcode 4 writes the address of the following instruction to the effective address and continues at the effective address plus 1.
- R10: Opcode 5 continues at the effective address and makes no memory access in its execute step.
- R11: Cycle counts, counted from fetch strobe to the next fetch strobe, are as follows. Opcodes 0, 1 and 2 take 4 cycles. Opcodes 3, 4 and 5 take 3 cycles. Indirection adds 2 cycles. Read and write strobes are never high together.
- R12: For opcode 6 or 7, the third cycle of the instruction raises ext_valid for exactly one cycle, with ext_word equal to the fetched word. No memory strobe is raised from then until ext_done is seen high, and ext_done is sampled only after the pulse. The next fetch strobe comes in the cycle after ext_done is seen. The accumulator is unchanged.
- R13: The program counter advances by 1 modulo 4096 at each fetch. A fetch at 7777 octal is followed by a fetch at 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 12 | Data to write |
| mem_rdata | input | 12 | Read data, valid the cycle after a read strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| ext_valid | output | 1 | One-cycle pulse handing an opcode 6/7 word out |
| ext_word | output | 12 | Handed-out instruction word |
| ext_done | input | 1 | Neighbour finished; sequencer resumes fetching |
| acc_o | output | 12 | Accumulator |
| link_o | output | 1 | Link bit |
| pc_o | output | 12 | Program counter |

## Verification
The bench builds the block with the default 7-bit offset and with RESET_PC at 0200 octal. Every test program therefore starts at the first word of page one. At that address, current-page and page-zero references land on different locations, so a wrong choice of page base is visible. The same setting lets a short jump reach the last word of page one, where the instruction's own page must still be used after the counter has stepped past it. A pointer to 7777 brings the counter wrap within a few cycles.

// File: rtl/pgref_pkg.sv
package pgref_pkg;
  localparam int OPC_W = 3;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_FETCH_W,
    ST_DEFER,
    ST_DEFER_W,
    ST_EXEC,
    ST_EXEC_W,
    ST_HAND,
    ST_EXT_WAIT
  } seq_state_t;

  typedef enum logic [OPC_W-1:0] {
    OP_AND  = 3'd0,
    OP_TAD  = 3'd1,
    OP_ISZ  = 3'd2,
    OP_DCA  = 3'd3,
    OP_JMS  = 3'd4,
    OP_JMP  = 3'd5,
    OP_EXT6 = 3'd6,
    OP_EXT7 = 3'd7
  } opcode_t;
endpackage

// File: rtl/pgref_decode.sv
module pgref_decode
  import pgref_pkg::*;
#(
  parameter int OFS_W  = 7,
  parameter int WORD_W = OPC_W + 2 + OFS_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] here,
  output opcode_t           op,
  output logic              indirect,
  output logic              ext,
  output logic [WORD_W-1:0] ea
);
  localparam int PAGE_W = WORD_W - OFS_W;

  logic page_sel;
  logic [PAGE_W-1:0] page_base;

  assign op       = opcode_t'(word[WORD_W-1 -: OPC_W]);
  assign indirect = word[OFS_W+1];
  assign page_sel = word[OFS_W];
  assign ext      = (op == OP_EXT6) || (op == OP_EXT7);

  // page base comes from the instruction's own address, not the stepped counter
  assign page_base = page_sel ? here[WORD_W-1 -: PAGE_W] : '0;
  assign ea        = {page_base, word[OFS_W-1:0]};
endmodule

// File: rtl/pgref_alu.sv
module pgref_alu
  import pgref_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  opcode_t           op,
  input  logic [WORD_W-1:0] acc,
  input  logic              link,
  input  logic [WORD_W-1:0] opnd,
  output logic [WORD_W-1:0] acc_next,
  output logic              link_next,
  output logic [WORD_W-1:0] inc_val,
  output logic              inc_zero
);
  logic [WORD_W:0] sum;

  assign sum      = {1'b0, acc} + {1'b0, opnd};
  assign inc_val  = opnd + WORD_W'(1);
  assign inc_zero = (inc_val == '0);

  always_comb begin
    acc_next  = acc;
    link_next = link;
    case (op)
      OP_AND: acc_next = acc & opnd;
      OP_TAD: begin
        acc_next  = sum[WORD_W-1:0];
        link_next = link ^ sum[WORD_W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pgref_sequencer.sv
module pgref_sequencer
  import pgref_pkg::*;
#(
  parameter int          OFS_W    = 7,
  parameter int unsigned RESET_PC = 0
) (
  input  logic                         clk,
  input  logic                         rst,
  output logic [OPC_W+2+OFS_W-1:0]     mem_addr,
  output logic [OPC_W+2+OFS_W-1:0]     mem_wdata,
  input  logic [OPC_W+2+OFS_W-1:0]     mem_rdata,
  output logic                         mem_rd,
  output logic                         mem_wr,
  output logic                         ext_valid,
  output logic [OPC_W+2+OFS_W-1:0]     ext_word,
  input  logic                         ext_done,
  output logic [OPC_W+2+OFS_W-1:0]     acc_o,
  output logic                         link_o,
  output logic [OPC_W+2+OFS_W-1:0]     pc_o
);
  localparam int WORD_W = OPC_W + 2 + OFS_W;
  localparam logic [WORD_W-1:0] PC_INIT = WORD_W'(RESET_PC);
  localparam logic [WORD_W-1:0] ONE     = WORD_W'(1);

  seq_state_t        state;
  logic [WORD_W-1:0] pc, acc, ir, ea;
  logic              link;

  opcode_t           dec_op, op;
  logic              dec_ind, dec_ext;
  logic [WORD_W-1:0] dec_ea;

  logic [WORD_W-1:0] alu_acc, inc_val;
  logic              alu_link, inc_zero;

  pgref_decode #(.OFS_W(OFS_W), .WORD_W(WORD_W)) u_decode (
    .word     (mem_rdata),
    .here     (pc),
    .op       (dec_op),
    .indirect (dec_ind),
    .ext      (dec_ext),
    .ea       (dec_ea)
  );

  assign op = opcode_t'(ir[WORD_W-1 -: OPC_W]);

  pgref_alu #(.WORD_W(WORD_W)) u_alu (
    .op        (op),
    .acc       (acc),
    .link      (link),
    .opnd      (mem_rdata),
    .acc_next  (alu_acc),
    .link_next (alu_link),
    .inc_val   (inc_val),
    .inc_zero  (inc_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      pc    <= PC_INIT;
      acc   <= '0;
      link  <= 1'b0;
      ir    <= '0;
      ea    <= '0;
    end else begin
      case (state)
        ST_FETCH: state <= ST_FETCH_W;
        ST_FETCH_W: begin
          ir <= mem_rdata;
          ea <= dec_ea;
          pc <= pc + ONE;
          if (dec_ext)       state <= ST_HAND;
          else if (dec_ind)  state <= ST_DEFER;
          else               state <= ST_EXEC;
        end
        ST_DEFER: state <= ST_DEFER_W;
        ST_DEFER_W: begin
          ea    <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          case (op)
            OP_AND, OP_TAD, OP_ISZ: state <= ST_EXEC_W;
            OP_DCA: begin
              acc   <= '0;
              state <= ST_FETCH;
            end
            OP_JMS: begin
              pc    <= ea + ONE;
              state <= ST_FETCH;
            end
            OP_JMP: begin
              pc    <= ea;
              state <= ST_FETCH;
            end
            default: state <= ST_FETCH;
          endcase
        end
        ST_EXEC_W: begin
          if (op == OP_ISZ) begin
            if (inc_zero) pc <= pc + ONE;
          end else begin
            acc  <= alu_acc;
            link <= alu_link;
          end
          state <= ST_FETCH;
        end
        ST_HAND: state <= ST_EXT_WAIT;
        ST_EXT_WAIT: if (ext_done) state <= ST_FETCH;
        default: state <= ST_FETCH;
      endcase
    end
  end

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = ea;
    mem_wdata = acc;
    case (state)
      ST_FETCH: begin
        mem_rd   = 1'b1;
        mem_addr = pc;
      end
      ST_DEFER: mem_rd = 1'b1;
      ST_EXEC: begin
        case (op)
          OP_AND, OP_TAD, OP_ISZ: mem_rd = 1'b1;
          OP_DCA: mem_wr = 1'b1;
          OP_JMS: begin
            mem_wr    = 1'b1;
            mem_wdata = pc;
          end
          default: ;
        endcase
      end
      ST_EXEC_W: begin
        if (op == OP_ISZ) begin
          mem_wr    = 1'b1;
          mem_wdata = inc_val;
        end
      end
      default: ;
    endcase
  end

  assign ext_valid = (state == ST_HAND);
  assign ext_word  = ir;
  assign acc_o     = acc;
  assign link_o    = link;
  assign pc_o      = pc;
endmodule

// File: rtl/pgref_sequencer_chk.sv
module pgref_sequencer_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [WORD_W-1:0] mem_rdata,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              ext_valid,
  input logic [WORD_W-1:0] acc_o,
  input logic              link_o
);
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_rmw_same_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_rd)) |->
      (mem_addr == $past(mem_addr) && mem_wdata == mem_rdata + WORD_W'(1)));

  p_rmw_acc_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_rd)) |-> ($stable(acc_o) && $stable(link_o)));

  p_link_after_read_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(link_o) |-> $past(mem_rd, 2));

  p_hand_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    ext_valid |=> (!ext_valid && !mem_rd && !mem_wr));

  p_hand_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    ext_valid |-> (!mem_rd && !mem_wr));
endmodule

bind pgref_sequencer pgref_sequencer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .ext_valid (ext_valid),
  .acc_o     (acc_o),
  .link_o    (link_o)
);

// File: tb/pgref_sequencer_tb_top.sv
module pgref_sequencer_tb_top;
  localparam int W = 12;
  localparam int NV = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst = 1'b1;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata, ext_word, acc_o, pc_o;
  logic         mem_rd, mem_wr, ext_valid, link_o;
  logic         ext_done = 1'b0;

  pgref_sequencer #(.OFS_W(7), .RESET_PC('o200)) dut_i (
    .clk(clk), .rst(rst),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ext_valid(ext_valid), .ext_word(ext_word), .ext_done(ext_done),
    .acc_o(acc_o), .link_o(link_o), .pc_o(pc_o)
  );

  // bench memory: one-clock read latency, write at end of cycle
  logic [W-1:0] mem [4096];
  logic         tb_clr = 1'b0, tb_wr = 1'b0;
  logic [W-1:0] tb_addr = '0, tb_data = '0;

  always @(posedge clk) begin
    if (tb_clr) begin
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
    end else if (tb_wr) begin
      mem[tb_addr] <= tb_data;
    end else begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
    end
  end

  int checks = 0, fails = 0, cur = 0;
  bit finished = 1'b0;

  task automatic check_eq(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %o expected %o", req, act, exp);
    end
  endtask

  task automatic poke(input logic [W-1:0] a, input logic [W-1:0] d);
    tb_addr = a; tb_data = d; tb_wr = 1'b1;
    @(negedge clk);
    tb_wr = 1'b0;
  endtask

  task automatic begin_load();
    rst = 1'b1;
    @(negedge clk);
    tb_clr = 1'b1;
    @(negedge clk);
    tb_clr = 1'b0;
  endtask

  task automatic release_rst();
    rst = 1'b0;
    cur = 0;
  endtask

  task automatic go(input int k);
    while (cur < k) begin
      @(negedge clk);
      cur++;
    end
  endtask

  // fields: acc0, instr, a0, d0, a1, d1, cycles, exp_acc, exp_link, exp_pc, chk_addr, chk_data
  localparam logic [12*W-1:0] VEC [NV] = '{
    {12'o7070, 12'o0050, 12'o0050, 12'o1234, 12'o0000, 12'o0000, 12'd4, 12'o1030, 12'd0, 12'o0202, 12'o0050, 12'o1234},
    {12'o0001, 12'o1260, 12'o0260, 12'o0017, 12'o0060, 12'o0400, 12'd4, 12'o0020, 12'd0, 12'o0202, 12'o0260, 12'o0017},
    {12'o7777, 12'o1050, 12'o0050, 12'o0002, 12'o0000, 12'o0000, 12'd4, 12'o0001, 12'd1, 12'o0202, 12'o0050, 12'o0002},
    {12'o0005, 12'o1430, 12'o0030, 12'o3000, 12'o3000, 12'o0100, 12'd6, 12'o0105, 12'd0, 12'o0202, 12'o0030, 12'o3000},
    {12'o0123, 12'o2050, 12'o0050, 12'o0041, 12'o0000, 12'o0000, 12'd4, 12'o0123, 12'd0, 12'o0202, 12'o0050, 12'o0042},
    {12'o0123, 12'o2050, 12'o0050, 12'o7777, 12'o0000, 12'o0000, 12'd4, 12'o0123, 12'd0, 12'o0203, 12'o0050, 12'o0000},
    {12'o4321, 12'o3050, 12'o0050, 12'o0000, 12'o0000, 12'o0000, 12'd3, 12'o0000, 12'd0, 12'o0202, 12'o0050, 12'o4321},
    {12'o0007, 12'o4300, 12'o0300, 12'o0000, 12'o0000, 12'o0000, 12'd3, 12'o0007, 12'd0, 12'o0301, 12'o0300, 12'o0202},
    {12'o0000, 12'o5440, 12'o0040, 12'o1234, 12'o0000, 12'o0000, 12'd5, 12'o0000, 12'd0, 12'o1234, 12'o0040, 12'o1234},
    {12'o0000, 12'o5077, 12'o0077, 12'o0000, 12'o0000, 12'o0000, 12'd3, 12'o0000, 12'd0, 12'o0077, 12'o0077, 12'o0000},
    {12'o0066, 12'o3420, 12'o0020, 12'o0500, 12'o0500, 12'o1111, 12'd5, 12'o0000, 12'd0, 12'o0202, 12'o0500, 12'o0066},
    {12'o0000, 12'o2421, 12'o0021, 12'o0600, 12'o0600, 12'o7777, 12'd6, 12'o0000, 12'd0, 12'o0203, 12'o0600, 12'o0000}
  };

  localparam string VTAG [NV] = '{
    "R5 R2 AND page zero", "R3 R6 TAD current page", "R6 TAD carry inverts link",
    "R4 R6 TAD indirect", "R7 ISZ no skip", "R7 ISZ skip on zero", "R8 DCA direct",
    "R9 JMS current page", "R10 R4 JMP indirect", "R10 JMP page zero",
    "R8 R4 DCA indirect", "R7 R4 ISZ indirect skip"
  };

  initial begin
    // R1: reset state and first fetch
    begin_load();
    poke(12'o0200, 12'o7000);
    release_rst();
    check_eq("R1 pc at reset", pc_o, 12'o0200);
    check_eq("R1 acc at reset", acc_o, 12'o0000);
    check_eq("R1 link at reset", {11'd0, link_o}, 12'd0);
    check_eq("R1 first read strobe", {11'd0, mem_rd}, 12'd1);
    check_eq("R1 first read address", mem_addr, 12'o0200);
    check_eq("R1 no handoff at reset", {11'd0, ext_valid}, 12'd0);

    // vector table: TAD 0010 preloads the accumulator, then the instruction under test at 0201
    for (int v = 0; v < NV; v++) begin
      logic [12*W-1:0] e;
      e = VEC[v];
      begin_load();
      poke(12'o0200, 12'o1010);
      poke(12'o0010, e[11*W +: W]);
      poke(12'o0201, e[10*W +: W]);
      poke(e[9*W +: W], e[8*W +: W]);
      poke(e[7*W +: W], e[6*W +: W]);
      release_rst();
      go(4 + int'(e[5*W +: W]));
      check_eq({VTAG[v], " R11 fetch strobe at expected cycle"}, {11'd0, mem_rd}, 12'd1);
      check_eq({VTAG[v], " R11 next fetch address"}, mem_addr, e[2*W +: W]);
      check_eq({VTAG[v], " pc"}, pc_o, e[2*W +: W]);
      check_eq({VTAG[v], " acc"}, acc_o, e[4*W +: W]);
      check_eq({VTAG[v], " link"}, {11'd0, link_o}, e[3*W +: W]);
      check_eq({VTAG[v], " memory word"}, mem[e[W +: W]], e[0 +: W]);
    end

    // R3: last word of page one uses page one as its base
    begin_load();
    poke(12'o0200, 12'o5377);
    poke(12'o0377, 12'o1205);
    poke(12'o0205, 12'o0011);
    poke(12'o0405, 12'o0022);
    release_rst();
    go(7);
    check_eq("R3 page end fetch address", mem_addr, 12'o0400);
    check_eq("R3 page end operand from own page", acc_o, 12'o0011);

    // R13: counter wraps from 7777 to 0000
    begin_load();
    poke(12'o0200, 12'o5420);
    poke(12'o0020, 12'o7777);
    poke(12'o7777, 12'o1050);
    poke(12'o0050, 12'o0003);
    release_rst();
    go(9);
    check_eq("R13 fetch after 7777", mem_addr, 12'o0000);
    check_eq("R13 pc wrapped", pc_o, 12'o0000);
    check_eq("R13 acc from wrapped run", acc_o, 12'o0003);

    // R12: opcode 7 handoff and stall until done
    begin_load();
    poke(12'o0200, 12'o1010);
    poke(12'o0010, 12'o0555);
    poke(12'o0201, 12'o7200);
    release_rst();
    go(6);
    check_eq("R12 handoff pulse", {11'd0, ext_valid}, 12'd1);
    check_eq("R12 handoff word", ext_word, 12'o7200);
    check_eq("R12 no strobe in handoff", {10'd0, mem_rd, mem_wr}, 12'd0);
    go(7);
    check_eq("R12 pulse one cycle", {11'd0, ext_valid}, 12'd0);
    go(8);
    check_eq("R12 stalled without done", {10'd0, mem_rd, mem_wr}, 12'd0);
    go(9);
    ext_done = 1'b1;
    go(10);
    ext_done = 1'b0;
    check_eq("R12 fetch after done", {11'd0, mem_rd}, 12'd1);
    check_eq("R12 resume address", mem_addr, 12'o0202);
    check_eq("R12 acc kept", acc_o, 12'o0555);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule